// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the Type 0 configuration header of a single-function PCI target that exposes one memory window. The bus protocol engine presents each configuration access as a dword index, four byte enables and a write strobe. The block returns the addressed dword as combinational read data and applies writes at the next clock edge, honouring the byte enables. It holds the identification words, the command and status registers, the class and revision dword and one memory base address register of fixed size. It drives the decode enables and the programmed base to the rest of the target.

Three event inputs record parity errors, signalled system errors and target aborts in sticky status flags. Software clears each flag by writing a one to its bit. A one-cycle load strobe from an external serial-EEPROM reader replaces the default vendor and device identifiers. A comparator raises a memory hit when memory decoding is enabled and the upper address bits of a bus access fall inside the claimed window.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, dword index 0 reads 0x015213A8: device identifier 0x0152 in bits 31:16 and vendor identifier 0x13A8 in bits 15:0. Writes to this index are ignored.
- R2: A one-cycle pulse on `ee_load_valid` replaces the identifiers with `ee_device_id` (bits 31:16) and `ee_vendor_id` (bits 15:0). Index 0 returns these values from the next cycle on.
- R3: Command bits 0 (I/O enable), 1 (memory enable), 6 (parity response enable) and 8 (SERR driver enable) are read/write and reset to 0. They drive `io_space_en`, `mem_space_en`, `perr_resp_en` and `serr_drv_en`. All other bits of 15:0 at index 1 read 0 and ignore writes.
- R4: A cycle with `ev_parity_err`, `ev_sys_err` or `ev_target_abort` high sets status bit 31, 30 or 27 at index 1 on the following edge. The bit then holds until it is cleared.
- R5: A write to index 1 with byte enable 3 set and a 1 in bit 31, 30 or 27 clears that flag. A 0 in the bit, or a clear byte enable 3, leaves it unchanged. An event in the same cycle as a clear wins.
- R6: The fixed status bits of index 1 read bits 26:25 = 01 and bit 23 = 1. Bits 29:28, 24 and 22:16 read 0. With no flag set and a zero command, index 1 reads 0x02800000.
- R7: Index 2 is read-only and returns class code 0x070002 in bits 31:8 and the revision parameter (default 0x01) in bits 7:0.
- R8: Index 3 (BIST, header type, latency timer, cache line size), index 5 (second BAR) and every index from 6 upward read 0 and ignore writes.
- R9: The BAR at index 4 has bits 31:10 read/write and reset to 0. Bits 9:0 read 0. Writing 0xFFFFFFFF with all byte enables reads back 0xFFFFFC00. `bar_base` carries the same value.
- R10: A write to index 1 or 4 changes only the bytes whose enable is set.
- R11: `mem_hit` is 1 exactly when the memory enable bit is 1 and `bus_addr[31:10]` equals BAR bits 31:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the current access |
| cfg_dw_idx | input | 6 | Dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables, bit n for bits 8n+7:8n |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw_idx` |
| ev_parity_err | input | 1 | Parity error detected event |
| ev_sys_err | input | 1 | System error signalled event |
| ev_target_abort | input | 1 | Target abort signalled event |
| ee_load_valid | input | 1 | Identifier load strobe from EEPROM reader |
| ee_vendor_id | input | 16 | Vendor identifier from EEPROM |
| ee_device_id | input | 16 | Device identifier from EEPROM |
| bus_addr | input | 32 | Address of the current bus access |
| mem_space_en | output | 1 | Memory decode enable |
| io_space_en | output | 1 | I/O decode enable |
| perr_resp_en | output | 1 | Parity error response enable |
| serr_drv_en | output | 1 | SERR driver enable |
| bar_base | output | 32 | Programmed window base |
| mem_hit | output | 1 | Bus address falls in the enabled window |

## Verification
The bench sweeps all sixteen byte-enable patterns over the BAR and the command word. A design that ignored the enables, or that let the low ten BAR bits be written, would read back the wrong merged value. It reads all 64 indices, which catches a decoder that aliases the upper indices onto real registers. It tests the sticky flags against a zero write, a one write with byte 3 disabled, a proper clear, and a clear in the same cycle as an event. A design that cleared on a write of zero, or let the clear win over the event, would lose a flag. It checks that a write to index 0 does not change the identifiers. It sweeps bus addresses just inside and just outside the window, with the memory enable on and off, which exposes a comparator that uses the wrong bit range or ignores the enable.

// File: rtl/cfg_space_pkg.sv
// Package: shared dword indices and fixed field values for the configuration header.
// Assumes: dword indices are byte offsets divided by four.
package cfg_space_pkg;
    localparam int IDX_W = 6;
    localparam logic [IDX_W-1:0] IDX_ID     = 6'd0;
    localparam logic [IDX_W-1:0] IDX_CMDSTS = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_MISC   = 6'd3;
    localparam logic [IDX_W-1:0] IDX_BAR0   = 6'd4;
    localparam logic [1:0]  DEVSEL_MEDIUM   = 2'b01;

    // Status flag bundle kept by the command/status unit
    typedef struct packed {
        logic perr;
        logic serr;
        logic tabort;
    } sts_flags_t;
endpackage

// File: rtl/cfg_id_regs.sv
// Module: holds vendor and device identifiers.
// Resets to parameter defaults; a single-cycle load strobe replaces both words.
// Assumes: the EEPROM reader presents stable words while ee_load_valid is high.
module cfg_id_regs #(
    parameter logic [15:0] DEF_VENDOR = 16'h13A8,
    parameter logic [15:0] DEF_DEVICE = 16'h0152
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_valid,
    input  logic [15:0] ld_vendor,
    input  logic [15:0] ld_device,
    output logic [15:0] vendor_id,
    output logic [15:0] device_id
);
    // Identifier capture: defaults at reset, EEPROM words on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vendor_id <= DEF_VENDOR;
            device_id <= DEF_DEVICE;
        end else if (ld_valid) begin
            vendor_id <= ld_vendor;
            device_id <= ld_device;
        end
    end
endmodule

// File: rtl/cfg_cmd_status.sv
// Module: command enables and sticky write-one-to-clear status flags.
// Assumes: wr_en is already qualified with the command/status dword index.
// An event arriving in the same cycle as a clear keeps its flag set.
module cfg_cmd_status
    import cfg_space_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        ev_perr,
    input  logic        ev_serr,
    input  logic        ev_tabort,
    output logic        io_en,
    output logic        mem_en,
    output logic        perr_en,
    output logic        serr_en,
    output sts_flags_t  flags
);
    sts_flags_t clr;

    // Clear requests: a one in the flag bit with the top byte enabled
    always_comb begin
        clr.perr   = wr_en && be[3] && wdata[31];
        clr.serr   = wr_en && be[3] && wdata[30];
        clr.tabort = wr_en && be[3] && wdata[27];
    end

    // Command bits in byte 0 (bits 6, 1, 0) and byte 1 (bit 8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_en   <= 1'b0;
            mem_en  <= 1'b0;
            perr_en <= 1'b0;
            serr_en <= 1'b0;
        end else if (wr_en) begin
            if (be[0]) begin
                io_en   <= wdata[0];
                mem_en  <= wdata[1];
                perr_en <= wdata[6];
            end
            if (be[1]) serr_en <= wdata[8];
        end
    end

    // Sticky flags: set by event, cleared by write-one, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags.perr   <= ev_perr   || (flags.perr   && !clr.perr);
            flags.serr   <= ev_serr   || (flags.serr   && !clr.serr);
            flags.tabort <= ev_tabort || (flags.tabort && !clr.tabort);
        end
    end
endmodule

// File: rtl/cfg_mem_bar.sv
// Module: memory base address register with a fixed power-of-two window.
// Bits below SIZE_LOG2 are hardwired to zero; upper bits are written per byte.
// Assumes: wr_en is already qualified with the BAR dword index.
module cfg_mem_bar #(
    parameter int SIZE_LOG2 = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic        mem_en,
    input  logic [31:0] bus_addr,
    output logic [31:0] base,
    output logic        hit
);
    localparam logic [31:0] WR_MASK = ~((32'd1 << SIZE_LOG2) - 32'd1);

    logic [31:0] base_q;

    // One register slice per byte lane, masked to the writable bits
    for (genvar b = 0; b < 4; b++) begin : g_lane
        localparam logic [7:0] LANE_MASK = WR_MASK[8*b +: 8];
        // Byte-lane update honouring its enable and the writable mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[8*b +: 8] <= 8'h00;
            else if (wr_en && be[b])
                base_q[8*b +: 8] <= wdata[8*b +: 8] & LANE_MASK;
        end
    end

    assign base = base_q;

    // Window compare on the address bits above the window size
    always_comb begin
        hit = mem_en && (bus_addr[31:SIZE_LOG2] == base_q[31:SIZE_LOG2]);
    end
endmodule

// File: rtl/cfg_space_regs.sv
// Module: Type 0 configuration header register file for a single-function target.
// Decodes dword index and byte enables, applies writes on the clock edge and
// returns read data combinationally. Unlisted indices read zero.
// Assumes: the bus engine holds index, enables and data stable around the edge.
module cfg_space_regs
    import cfg_space_pkg::*;
#(
    parameter logic [15:0] DEF_VENDOR = 16'h13A8,
    parameter logic [15:0] DEF_DEVICE = 16'h0152,
    parameter logic [23:0] CLASS_CODE = 24'h070002,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter int          BAR_LOG2   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_dw_idx,
    input  logic [3:0]       cfg_be,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             ev_parity_err,
    input  logic             ev_sys_err,
    input  logic             ev_target_abort,
    input  logic             ee_load_valid,
    input  logic [15:0]      ee_vendor_id,
    input  logic [15:0]      ee_device_id,
    input  logic [31:0]      bus_addr,
    output logic             mem_space_en,
    output logic             io_space_en,
    output logic             perr_resp_en,
    output logic             serr_drv_en,
    output logic [31:0]      bar_base,
    output logic             mem_hit
);
    logic [15:0] vendor_id, device_id;
    sts_flags_t  flags;
    logic        wr_cmd, wr_bar;

    // Write qualification per implemented writable dword
    always_comb begin
        wr_cmd = cfg_wr && (cfg_dw_idx == IDX_CMDSTS);
        wr_bar = cfg_wr && (cfg_dw_idx == IDX_BAR0);
    end

    cfg_id_regs #(.DEF_VENDOR(DEF_VENDOR), .DEF_DEVICE(DEF_DEVICE)) u_id (
        .clk(clk), .rst_n(rst_n), .ld_valid(ee_load_valid),
        .ld_vendor(ee_vendor_id), .ld_device(ee_device_id),
        .vendor_id(vendor_id), .device_id(device_id)
    );

    cfg_cmd_status u_cs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .be(cfg_be), .wdata(cfg_wdata),
        .ev_perr(ev_parity_err), .ev_serr(ev_sys_err), .ev_tabort(ev_target_abort),
        .io_en(io_space_en), .mem_en(mem_space_en), .perr_en(perr_resp_en),
        .serr_en(serr_drv_en), .flags(flags)
    );

    cfg_mem_bar #(.SIZE_LOG2(BAR_LOG2)) u_bar (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_bar), .be(cfg_be), .wdata(cfg_wdata),
        .mem_en(mem_space_en), .bus_addr(bus_addr), .base(bar_base), .hit(mem_hit)
    );

    // Read multiplexer assembling each dword from its fields
    always_comb begin
        cfg_rdata = '0;
        case (cfg_dw_idx)
            IDX_ID:     cfg_rdata = {device_id, vendor_id};
            IDX_CMDSTS: cfg_rdata = {flags.perr, flags.serr, 2'b00, flags.tabort,
                                     DEVSEL_MEDIUM, 1'b0, 1'b1, 7'd0,
                                     7'd0, serr_drv_en, 1'b0, perr_resp_en,
                                     4'd0, mem_space_en, io_space_en};
            IDX_CLASS:  cfg_rdata = {CLASS_CODE, REV_ID};
            IDX_BAR0:   cfg_rdata = bar_base;
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_space_regs_chk.sv
// Module: assertion checker for cfg_space_regs, attached by bind below.
// Observes ports and the outputs of the internal units.
module cfg_space_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [5:0]  cfg_dw_idx,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        ev_parity_err,
    input logic        ee_load_valid,
    input logic [15:0] ee_vendor_id,
    input logic [15:0] vendor_id,
    input logic        perr_flag,
    input logic        mem_space_en,
    input logic        mem_hit,
    input logic [31:0] bar_base
);
    // R4: a parity event sets the flag on the next edge
    assert_perr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_parity_err |=> perr_flag);

    // R5: the flag survives any cycle without a qualifying clear
    assert_perr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !(cfg_wr && cfg_dw_idx == 6'd1 && cfg_be[3] && cfg_wdata[31]))
        |=> perr_flag);

    // R2: a load strobe installs the EEPROM vendor word
    assert_ee_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ee_load_valid |=> (vendor_id == $past(ee_vendor_id)));

    // R11: no hit while memory decoding is disabled
    assert_hit_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> mem_space_en);

    // R9: writes to other indices leave the BAR unchanged
    assert_bar_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_dw_idx != 6'd4) |=> $stable(bar_base));

    // R8: the miscellaneous dword always reads zero
    assert_misc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_idx == 6'd3) |-> (cfg_rdata == 32'd0));
endmodule

bind cfg_space_regs cfg_space_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_idx(cfg_dw_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ev_parity_err(ev_parity_err), .ee_load_valid(ee_load_valid),
    .ee_vendor_id(ee_vendor_id), .vendor_id(vendor_id), .perr_flag(flags.perr),
    .mem_space_en(mem_space_en), .mem_hit(mem_hit), .bar_base(bar_base)
);

// File: tb/cfg_space_regs_tb.sv
module cfg_space_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ev_parity_err = 1'b0, ev_sys_err = 1'b0, ev_target_abort = 1'b0;
    logic        ee_load_valid = 1'b0;
    logic [15:0] ee_vendor_id = '0, ee_device_id = '0;
    logic [31:0] bus_addr = '0;
    logic        mem_space_en, io_space_en, perr_resp_en, serr_drv_en, mem_hit;
    logic [31:0] bar_base;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_space_regs u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write at a negedge, let the posedge apply it
    task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw_idx = idx; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] idx, output logic [31:0] d);
        cfg_dw_idx = idx;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] bemask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? 8'hFF : 8'h00;
        return m;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, exp_bar, exp_cmd, base_v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset identifiers, writes ignored
        rd(6'd0, d); chk("R1 reset id", d, 32'h015213A8);
        wr(6'd0, 4'hF, 32'hDEADBEEF);
        rd(6'd0, d); chk("R1 id write ignored", d, 32'h015213A8);
        // R6/R3: reset command/status
        rd(6'd1, d); chk("R6 status reset", d, 32'h02800000);
        chk("R3 enables reset", {28'd0, serr_drv_en, perr_resp_en, mem_space_en, io_space_en}, 32'd0);
        // R7
        rd(6'd2, d); chk("R7 class rev", d, 32'h07000201);
        // R9 reset
        rd(6'd4, d); chk("R9 bar reset", d, 32'd0);

        // R8: sweep all indices after writing ones to each
        for (int i = 0; i < 64; i++) begin
            if (i != 1 && i != 4) wr(i[5:0], 4'hF, 32'hFFFFFFFF);
        end
        for (int i = 3; i < 64; i++) begin
            if (i != 4) begin
                rd(i[5:0], d); chk("R8 zero index", d, 32'd0);
            end
        end
        rd(6'd0, d); chk("R1 id after sweep", d, 32'h015213A8);
        rd(6'd2, d); chk("R7 class after write", d, 32'h07000201);

        // R9/R10: BAR byte-enable sweep
        exp_bar = 32'd0;
        for (int be = 0; be < 16; be++) begin
            d = 32'hA5C3_F00F ^ {be[3:0], be[3:0], 24'h5A5A5A};
            wr(6'd4, be[3:0], d);
            exp_bar = (exp_bar & ~bemask(be[3:0])) | (d & bemask(be[3:0]) & 32'hFFFFFC00);
            rd(6'd4, d); chk("R10 bar byte enables", d, exp_bar);
            chk("R9 bar_base port", bar_base, exp_bar);
        end
        wr(6'd4, 4'hF, 32'hFFFFFFFF);
        rd(6'd4, d); chk("R9 bar all ones", d, 32'hFFFFFC00);

        // R3/R10: command byte-enable sweep
        exp_cmd = 32'd0;
        for (int be = 0; be < 16; be++) begin
            d = (be % 2 == 1) ? 32'h0000FFFF : 32'h0000FEBC;
            d = d ^ {16'd0, 7'd0, be[2], 1'b0, be[1], 4'd0, be[0], be[3]};
            wr(6'd1, be[3:0], d & 32'h0000FFFF);
            if (be[0]) exp_cmd[6:0] = {d[6], 4'd0, d[1], d[0]};
            if (be[1]) exp_cmd[8] = d[8];
            rd(6'd1, d); chk("R3 command bits", d, 32'h02800000 | exp_cmd);
            chk("R3 enable ports", {23'd0, serr_drv_en, 1'b0, perr_resp_en, 4'd0, mem_space_en, io_space_en}, exp_cmd);
        end

        // R11: window compare sweep (memory enable on)
        wr(6'd1, 4'h1, 32'h00000002);
        wr(6'd4, 4'hF, 32'h8000_0400);
        base_v = 32'h8000_0400;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] a;
            case (k)
                0: a = base_v;
                1: a = base_v + 32'h3FF;
                2: a = base_v - 32'h1;
                3: a = base_v + 32'h400;
                4: a = base_v + 32'h200;
                5: a = base_v ^ 32'h8000_0000;
                6: a = 32'h0;
                default: a = base_v | 32'h0000_0155;
            endcase
            bus_addr = a; #1;
            chk("R11 mem_hit", {31'd0, mem_hit}, {31'd0, a[31:10] == base_v[31:10]});
        end
        wr(6'd1, 4'h1, 32'h00000000);
        bus_addr = base_v; #1;
        chk("R11 hit disabled", {31'd0, mem_hit}, 32'd0);

        // R4/R5: sticky flags
        @(negedge clk); ev_parity_err = 1'b1; ev_sys_err = 1'b1; ev_target_abort = 1'b1;
        @(negedge clk); ev_parity_err = 1'b0; ev_sys_err = 1'b0; ev_target_abort = 1'b0;
        repeat (2) @(negedge clk);
        rd(6'd1, d); chk("R4 flags set", d, 32'hCA80_0100 & 32'hFFFF0000 | (exp_cmd & 32'h100) );
        wr(6'd1, 4'hF, exp_cmd & 32'h0000FFFF);
        rd(6'd1, d); chk("R5 zero write keeps", d[31:16], 32'h0000CA80);
        wr(6'd1, 4'h7, 32'hFFFF_0000 | (exp_cmd & 32'hFFFF));
        rd(6'd1, d); chk("R5 byte3 disabled keeps", d[31:16], 32'h0000CA80);
        wr(6'd1, 4'h8, 32'h8000_0000);
        rd(6'd1, d); chk("R5 clear perr only", d[31:16], 32'h00004A80);
        // Clear serr while a new serr event arrives: event wins
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw_idx = 6'd1; cfg_be = 4'h8; cfg_wdata = 32'h4800_0000;
        ev_sys_err = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0; ev_sys_err = 1'b0;
        rd(6'd1, d); chk("R5 event beats clear", d[31:16], 32'h00004280);
        wr(6'd1, 4'h8, 32'h4800_0000);
        rd(6'd1, d); chk("R6 status after clear", d[31:16], 32'h00000280);

        // R2: EEPROM load
        @(negedge clk);
        ee_load_valid = 1'b1; ee_vendor_id = 16'h1AB4; ee_device_id = 16'hC0DE;
        @(negedge clk);
        ee_load_valid = 1'b0; ee_vendor_id = 16'h0; ee_device_id = 16'h0;
        rd(6'd0, d); chk("R2 eeprom ids", d, 32'hC0DE1AB4);
        repeat (3) @(negedge clk);
        rd(6'd0, d); chk("R2 ids held", d, 32'hC0DE1AB4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule